// File: doc/BRIEF.md
# PHY Extended Register Access Sequencer

This block lets a host reach PHY registers that lie outside the 5-bit direct management address space. A request gives a 5-bit PHY address, a 16-bit extended register address, a direction, and (for writes) 16 bits of data. The block turns that request into four direct management transactions aimed at the PHY's indirect access register pair. These are a control write that selects address mode, a write of the target address, a control write that selects data mode, and a final data access that is either a read or a write. The control register sits at direct address 0x0D and the address/data register at 0x0E.

The block does not generate MDIO frames. It passes each transaction to a frame engine as a 32-bit command word, one word per `cmd_valid` cycle, and then tracks the engine's idle flag. It issues the next word only after the engine has gone busy and then become idle again. When the last access finishes, the block returns the read data with a one-cycle done pulse. It raises an error flag when a read returns all ones, which usually means no PHY answers at that address.

The main state machine has six states. `S_IDLE` accepts a request and moves to `S_CTRL1`. Each of `S_CTRL1`, `S_ADDR`, `S_CTRL2` and `S_DATA` issues its command and advances when its transaction completes. `S_DONE` drives the done pulse and returns to `S_IDLE`. A per-step handshake machine sits under it, with three states. `HS_ISSUE` fires the command when the engine is idle, `HS_LAUNCH` waits for the engine to go busy, and `HS_RUN` waits for the engine to become idle again.

Top module: `ext_reg_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `cmd_valid`, `rsp_done` and `rsp_err` are 0.
- R2: Every command word has this layout: bits 31:30 = 01 (start), bits 29:28 = operation (01 write, 10 read), bits 27:23 = PHY address, bits 22:18 = direct register, bits 17:16 = 10 (turnaround), bits 15:0 = write data (zero for reads).
- R3: The first command of a sequence writes 0x001F to direct register 0x0D.
- R4: The second command writes the requested 16-bit extended address to direct register 0x0E.
- R5: The third command writes 0x401F to direct register 0x0D, which selects data mode.
- R6: The fourth command reads direct register 0x0E for a read request, or writes the request data to 0x0E for a write request.
- R7: `cmd_valid` is raised only while `eng_idle` is 1. The next command is issued only after the engine has dropped `eng_idle` and raised it again. Exactly four commands are issued per request.
- R8: `req_ready` is 1 only when no sequence is running. A `req_valid` that arrives while a sequence runs starts nothing.
- R9: Once the fourth transaction completes, `rsp_done` is high for exactly one cycle. At that time `rsp_rdata` carries the value read by the fourth command for a read request, and 0 for a write request.
- R10: `rsp_err` is 1 together with `rsp_done` when a read request returns 0xFFFF. It is never 1 for a write request or outside the done cycle.
- R11: All four commands of a sequence carry the PHY address captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | High while idle and able to accept a request |
| req_write | input | 1 | 1 = extended write, 0 = extended read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 16 | Extended register address |
| req_wdata | input | 16 | Data for an extended write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| rsp_err | output | 1 | All-ones read result, valid with `rsp_done` |
| cmd_valid | output | 1 | Command word offered to the frame engine |
| cmd_word | output | 32 | Management command word |
| eng_idle | input | 1 | Frame engine is idle, and its last result is available |
| eng_rdata | input | 16 | Data returned by the engine's last read |

## Verification
Several properties are checked on every cycle. The done pulse lasts one cycle, and the error flag appears only with done and only for reads. No command is offered while `req_ready` is high. Every offered word carries the fixed start and turnaround bits, and the first word of a sequence has the address-mode control value. A step also never completes the cycle after its command fires, and the handshake holds until the engine goes busy. Only the bench scenarios can show the rest. These are the exact four-word series for reads and writes, with the captured PHY address. They also cover the returned data and error flag under different engine latencies, the rejection of a request made during a running sequence, and the absence of any command offered while the engine is busy.

// File: rtl/ext_seq_pkg.sv
package ext_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CTRL1,
        S_ADDR,
        S_CTRL2,
        S_DATA,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        HS_ISSUE,
        HS_LAUNCH,
        HS_RUN
    } hs_state_t;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] TA_CODE    = 2'b10;

endpackage

// File: rtl/ext_cmd_fmt.sv
module ext_cmd_fmt
    import ext_seq_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16,
    localparam int CMD_W = 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W
) (
    input  logic              is_read,
    input  logic [PHY_AW-1:0] phy,
    input  logic [REG_AW-1:0] regad,
    input  logic [DATA_W-1:0] data,
    output logic [CMD_W-1:0]  word
);

    logic [1:0]        op_code;
    logic [DATA_W-1:0] payload;

    always_comb begin
        op_code = is_read ? OP_READ : OP_WRITE;
        payload = is_read ? '0 : data;
        word    = {START_CODE, op_code, phy, regad, TA_CODE, payload};
    end

endmodule

// File: rtl/ext_step_hs.sv
module ext_step_hs
    import ext_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_active,
    input  logic eng_idle,
    output logic cmd_fire,
    output logic step_done
);

    hs_state_t hs_q, hs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= HS_ISSUE;
        else        hs_q <= hs_d;
    end

    always_comb begin
        hs_d      = hs_q;
        cmd_fire  = 1'b0;
        step_done = 1'b0;
        unique case (hs_q)
            HS_ISSUE: begin
                if (step_active && eng_idle) begin
                    cmd_fire = 1'b1;
                    hs_d     = HS_LAUNCH;
                end
            end
            HS_LAUNCH: begin
                if (!eng_idle) hs_d = HS_RUN;
            end
            HS_RUN: begin
                if (eng_idle) begin
                    step_done = 1'b1;
                    hs_d      = HS_ISSUE;
                end
            end
            default: hs_d = HS_ISSUE;
        endcase
    end

    // R7: a step cannot finish in the cycle right after its command fires
    a_r7_no_instant_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !step_done);

    // R7: after launch, stay put until the engine has gone busy
    a_r7_launch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q == HS_LAUNCH && eng_idle) |=> (hs_q == HS_LAUNCH));

endmodule

// File: rtl/ext_seq_fsm.sv
module ext_seq_fsm
    import ext_seq_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16,
    parameter logic [REG_AW-1:0] CTRL_REG = 5'h0D,
    parameter logic [REG_AW-1:0] ADDR_REG = 5'h0E,
    parameter logic [DATA_W-1:0] CTRL_ADDR_MODE = 16'h001F,
    parameter logic [DATA_W-1:0] CTRL_DATA_MODE = 16'h401F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PHY_AW-1:0] req_phy,
    input  logic [DATA_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              step_done,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              req_ready,
    output logic              step_active,
    output logic              op_read,
    output logic [PHY_AW-1:0] phy_out,
    output logic [REG_AW-1:0] reg_out,
    output logic [DATA_W-1:0] data_out,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output seq_state_t        cur_state
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    seq_state_t        state_q, state_d;
    logic              wr_q;
    logic [PHY_AW-1:0] phy_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              accept;

    assign accept = (state_q == S_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_CTRL1;
            S_CTRL1: if (step_done) state_d = S_ADDR;
            S_ADDR:  if (step_done) state_d = S_CTRL2;
            S_CTRL2: if (step_done) state_d = S_DATA;
            S_DATA:  if (step_done) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Request capture and result collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            phy_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            wr_q    <= req_write;
            phy_q   <= req_phy;
            addr_q  <= req_reg;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (state_q == S_DATA && step_done && !wr_q) begin
            rdata_q <= eng_rdata;
            err_q   <= (eng_rdata == ALL_ONES);
        end
    end

    // Outputs per state
    always_comb begin
        req_ready   = 1'b0;
        step_active = 1'b0;
        op_read     = 1'b0;
        reg_out     = CTRL_REG;
        data_out    = '0;
        rsp_done    = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_CTRL1: begin
                step_active = 1'b1;
                reg_out     = CTRL_REG;
                data_out    = CTRL_ADDR_MODE;
            end
            S_ADDR: begin
                step_active = 1'b1;
                reg_out     = ADDR_REG;
                data_out    = addr_q;
            end
            S_CTRL2: begin
                step_active = 1'b1;
                reg_out     = CTRL_REG;
                data_out    = CTRL_DATA_MODE;
            end
            S_DATA: begin
                step_active = 1'b1;
                op_read     = !wr_q;
                reg_out     = ADDR_REG;
                data_out    = wdata_q;
            end
            S_DONE:  rsp_done = 1'b1;
            default: req_ready = 1'b0;
        endcase
    end

    assign phy_out   = phy_q;
    assign rsp_rdata = rdata_q;
    assign rsp_err   = rsp_done && err_q;
    assign cur_state = state_q;

    // R9: the done state lasts one cycle and always goes back to idle
    a_r9_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> (state_q == S_IDLE));

    // R10: a write request never reports the all-ones error
    a_r10_no_err_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !wr_q);

    // R11: captured PHY address stays fixed while a sequence runs
    a_r11_phy_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (step_active && $past(step_active)) |-> $stable(phy_q));

endmodule

// File: rtl/ext_reg_seq.sv
module ext_reg_seq
    import ext_seq_pkg::*;
#(
    parameter int PHY_AW = 5,
    parameter int REG_AW = 5,
    parameter int DATA_W = 16,
    parameter int DEV_W  = 5,
    parameter logic [REG_AW-1:0] CTRL_REG = 5'h0D,
    parameter logic [REG_AW-1:0] ADDR_REG = 5'h0E,
    parameter logic [DEV_W-1:0]  DEVAD    = 5'h1F,
    localparam int CMD_W = 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [PHY_AW-1:0] req_phy,
    input  logic [DATA_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_word,
    input  logic              eng_idle,
    input  logic [DATA_W-1:0] eng_rdata
);

    localparam logic [1:0] FN_ADDR = 2'b00;
    localparam logic [1:0] FN_DATA = 2'b01;
    localparam int         PAD_W   = DATA_W - 2 - DEV_W;
    localparam logic [DATA_W-1:0] CTRL_ADDR_MODE = {FN_ADDR, {PAD_W{1'b0}}, DEVAD};
    localparam logic [DATA_W-1:0] CTRL_DATA_MODE = {FN_DATA, {PAD_W{1'b0}}, DEVAD};
    localparam int DATA_LSB = 0;
    localparam int REG_LSB  = DATA_W + 2;
    localparam int OP_LSB   = REG_LSB + REG_AW + PHY_AW;

    logic              step_active;
    logic              step_done;
    logic              cmd_fire;
    logic              op_read;
    logic [PHY_AW-1:0] phy_out;
    logic [REG_AW-1:0] reg_out;
    logic [DATA_W-1:0] data_out;
    seq_state_t        cur_state;

    ext_seq_fsm #(
        .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W),
        .CTRL_REG(CTRL_REG), .ADDR_REG(ADDR_REG),
        .CTRL_ADDR_MODE(CTRL_ADDR_MODE), .CTRL_DATA_MODE(CTRL_DATA_MODE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .step_done(step_done), .eng_rdata(eng_rdata),
        .req_ready(req_ready), .step_active(step_active), .op_read(op_read),
        .phy_out(phy_out), .reg_out(reg_out), .data_out(data_out),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cur_state(cur_state)
    );

    ext_step_hs u_hs (
        .clk(clk), .rst_n(rst_n),
        .step_active(step_active), .eng_idle(eng_idle),
        .cmd_fire(cmd_fire), .step_done(step_done)
    );

    ext_cmd_fmt #(.PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_fmt (
        .is_read(op_read), .phy(phy_out), .regad(reg_out),
        .data(data_out), .word(cmd_word)
    );

    assign cmd_valid = cmd_fire;

    // R8: no command is offered while the block is open for a new request
    a_r8_ready_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

    // R2: fixed start and turnaround bits in every offered word
    a_r2_frame_bits: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[CMD_W-1 -: 2] == START_CODE &&
                       cmd_word[REG_LSB-1 -: 2] == TA_CODE));

    // R3: first step is a write of the address-mode control value
    a_r3_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cur_state == S_CTRL1) |->
            (cmd_word[OP_LSB +: 2] == OP_WRITE &&
             cmd_word[REG_LSB +: REG_AW] == CTRL_REG &&
             cmd_word[DATA_LSB +: DATA_W] == CTRL_ADDR_MODE));

    // R10: the error flag only appears with the done pulse
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/tb_ext_reg_seq.sv
module tb_ext_reg_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [15:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic        cmd_valid;
    logic [31:0] cmd_word;
    logic        eng_idle;
    logic [15:0] eng_rdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int overlap = 0;

    // frame engine model
    int          busy = 0;
    int          lat = 2;
    logic [15:0] rd_value = 16'h0000;
    logic [31:0] log_w [0:63];
    int          nlog = 0;

    always #5 clk = ~clk;

    ext_reg_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .eng_idle(eng_idle), .eng_rdata(eng_rdata)
    );

    assign eng_idle = (busy == 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 0;
            eng_rdata <= 16'h0000;
        end else if (cmd_valid && busy == 0) begin
            busy <= lat;
            if (nlog < 64) log_w[nlog] <= cmd_word;
            nlog <= nlog + 1;
            if (cmd_word[29:28] == 2'b10) eng_rdata <= rd_value;
        end else if (busy > 0) begin
            busy <= busy - 1;
        end
    end

    always @(negedge clk) if (rst_n && cmd_valid && !eng_idle) overlap++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish (actual=%0d cycles, expected fewer)", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input bit rd, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, rd ? 16'h0000 : d};
    endfunction

    task automatic run_req(input bit wr, input logic [4:0] phy, input logic [15:0] ra,
                           input logic [15:0] wd, input int l, input logic [15:0] rv,
                           output logic [15:0] rdata, output logic err, output int base);
        int n = 0;
        lat = l;
        rd_value = rv;
        base = nlog;
        @(negedge clk);
        req_write = wr; req_phy = phy; req_reg = ra; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        rdata = rsp_rdata;
        err   = rsp_err;
        chk(rsp_done, "R9 done seen", {31'd0, rsp_done}, 32'd1);
        @(negedge clk);
        chk(!rsp_done, "R9 done one cycle", {31'd0, rsp_done}, 32'd0);
    endtask

    task automatic check_words(input int base, input bit wr, input logic [4:0] phy,
                               input logic [15:0] ra, input logic [15:0] wd);
        chk(nlog - base == 4, "R7 four commands", nlog - base, 4);
        chk(log_w[base]   == mkw(0, phy, 5'h0D, 16'h001F), "R3 R11 step one", log_w[base], mkw(0, phy, 5'h0D, 16'h001F));
        chk(log_w[base+1] == mkw(0, phy, 5'h0E, ra), "R4 R11 step two", log_w[base+1], mkw(0, phy, 5'h0E, ra));
        chk(log_w[base+2] == mkw(0, phy, 5'h0D, 16'h401F), "R5 R11 step three", log_w[base+2], mkw(0, phy, 5'h0D, 16'h401F));
        chk(log_w[base+3] == mkw(!wr, phy, 5'h0E, wd), "R6 R11 step four", log_w[base+3], mkw(!wr, phy, 5'h0E, wd));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", {31'd0, cmd_valid}, 32'd0);
        chk(rsp_done == 1'b0 && rsp_err == 1'b0, "R1 done/err", {30'd0, rsp_done, rsp_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_read_known;
        logic [15:0] rd; logic er; int b;
        run_req(0, 5'h0C, 16'h006E, 16'h0000, 2, 16'h1234, rd, er, b);
        chk(log_w[b] == 32'h5636001F, "R2 word one literal", log_w[b], 32'h5636001F);
        chk(log_w[b+1] == 32'h563A006E, "R2 word two literal", log_w[b+1], 32'h563A006E);
        chk(log_w[b+2] == 32'h5636401F, "R2 word three literal", log_w[b+2], 32'h5636401F);
        chk(log_w[b+3] == 32'h663A0000, "R2 word four literal", log_w[b+3], 32'h663A0000);
        check_words(b, 0, 5'h0C, 16'h006E, 16'h0000);
        chk(rd == 16'h1234, "R9 read data", {16'd0, rd}, 32'h1234);
        chk(er == 1'b0, "R10 no err", {31'd0, er}, 32'd0);
    endtask

    task automatic t_write;
        logic [15:0] rd; logic er; int b;
        run_req(1, 5'h03, 16'h00AB, 16'hBEEF, 5, 16'hFFFF, rd, er, b);
        check_words(b, 1, 5'h03, 16'h00AB, 16'hBEEF);
        chk(rd == 16'h0000, "R9 write rdata zero", {16'd0, rd}, 32'h0);
        chk(er == 1'b0, "R10 no err on write", {31'd0, er}, 32'd0);
    endtask

    task automatic t_read_absent;
        logic [15:0] rd; logic er; int b;
        run_req(0, 5'h1F, 16'hFFFF, 16'h0000, 1, 16'hFFFF, rd, er, b);
        check_words(b, 0, 5'h1F, 16'hFFFF, 16'h0000);
        chk(rd == 16'hFFFF, "R9 read all ones", {16'd0, rd}, 32'hFFFF);
        chk(er == 1'b1, "R10 err on all ones", {31'd0, er}, 32'd1);
    endtask

    task automatic t_busy_hold;
        int b; int n = 0; int seen_ready = 0;
        lat = 3;
        rd_value = 16'h0A5A;
        b = nlog;
        @(negedge clk);
        req_write = 0; req_phy = 5'h05; req_reg = 16'h0131; req_valid = 1'b1;
        @(negedge clk);
        req_phy = 5'h11; req_reg = 16'h0777; req_write = 1;
        repeat (4) begin
            if (req_ready) seen_ready++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!rsp_done && n < 2000) begin
            if (req_ready) seen_ready++;
            @(negedge clk);
            n++;
        end
        chk(seen_ready == 0, "R8 ready low while running", seen_ready, 0);
        chk(rsp_rdata == 16'h0A5A, "R9 read data busy case", {16'd0, rsp_rdata}, 32'h0A5A);
        repeat (3) @(negedge clk);
        check_words(b, 0, 5'h05, 16'h0131, 16'h0000);
        chk(req_ready == 1'b1, "R8 ready back", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        t_reset;
        t_read_known;
        t_write;
        t_read_absent;
        t_busy_hold;
        chk(overlap == 0, "R7 no command while engine busy", overlap, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule